// File: doc/BRIEF.md
# SHA-1 Message Schedule Stream

This block feeds a SHA-1 compression core with the 80 schedule words it needs for one 512-bit message block. It does not keep all 80 words. It holds only the 16 most recent words in a sliding register window and works out each later word as it is needed.

A load pulse copies the block into the window and presents word 0. Each step pulse moves the output on by one word. While the output is still inside the loaded words (0 to 15), the window stays put and the output selects the matching slot. From word 16 onward, every step computes a new word from the schedule recurrence, shifts the window down by one slot and places the new word in the top slot. The word that is shown is always the one that matches the internal round counter. After word 79, further steps do nothing until the next load.

Top module: `msg_sched_stream`

## Requirements
- R1: While rst_n is low, the window, the round counter and the control state are cleared, so word_o reads 0 after reset.
- R2: One cycle after a load_i pulse, word_o shows bits 511:480 of the blk_i value sampled in that cycle (word 0).
- R3: Each step_i pulse while word t is shown (t below 15) makes word_o show word t+1 one cycle later. Word k is blk_i bits 511-32k down to 480-32k, so the most significant word comes first.
- R4: For t from 16 to 79, word t equals W[t-3] xor W[t-8] xor W[t-14] xor W[t-16], rotated left by one bit, and it appears one cycle after the step_i that follows word t-1.
- R5: Once word 79 is shown, step_i pulses have no effect and word_o keeps word 79 until the next load.
- R6: load_i restarts the schedule at word 0 of the new block from any point in a run, and it wins over step_i in the same cycle.
- R7: step_i pulses after reset and before the first load have no effect, so word_o stays 0.
- R8: In a cycle with neither load_i nor step_i, word_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_i | input | 512 | Message block; sampled only in a load cycle |
| load_i | input | 1 | Load the block and restart at word 0 |
| step_i | input | 1 | Move on to the next schedule word |
| word_o | output | 32 | Schedule word for the current round |

## Verification
The assertions assume that load_i, step_i and blk_i are free of X or Z values and change only between rising edges. Any cycle in which either strobe is high is taken as one command. The bench drives every input on the falling edge and never leaves one undriven. It sends single-cycle pulses as well as overlapping load and step requests. It compares every word of many full 80-word runs against a schedule it computes itself.

// File: rtl/msg_sched_stream.sv
module msg_sched_stream #(
  parameter int WORD_W = 32,
  parameter int WIN    = 16,
  parameter int ROUNDS = 80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WORD_W*WIN-1:0] blk_i,
  input  logic                  load_i,
  input  logic                  step_i,
  output logic [WORD_W-1:0]     word_o
);
  localparam int CW    = $clog2(ROUNDS);
  localparam int SW    = $clog2(WIN);
  localparam int LAST  = ROUNDS - 1;
  localparam int TAP_A = WIN - 3;
  localparam int TAP_B = WIN - 8;
  localparam int TAP_C = WIN - 14;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;

  logic [WORD_W-1:0] win [WIN];
  logic [CW-1:0]     cnt;
  st_t               st;
  logic              adv, shift;
  logic [WORD_W-1:0] mix, fresh;

  assign adv   = step_i && !load_i && (st == S_RUN);
  assign shift = adv && (cnt >= CW'(WIN - 1));
  assign mix   = win[TAP_A] ^ win[TAP_B] ^ win[TAP_C] ^ win[0];
  assign fresh = {mix[WORD_W-2:0], mix[WORD_W-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) win[i] <= '0;
    end else if (load_i) begin
      for (int i = 0; i < WIN; i++) win[i] <= blk_i[(WIN-1-i)*WORD_W +: WORD_W];
    end else if (shift) begin
      for (int i = 0; i < WIN-1; i++) win[i] <= win[i+1];
      win[WIN-1] <= fresh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      st  <= S_IDLE;
    end else if (load_i) begin
      cnt <= '0;
      st  <= S_RUN;
    end else if (adv) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(LAST - 1)) st <= S_DONE;
    end
  end

  assign word_o = (cnt < CW'(WIN)) ? win[cnt[SW-1:0]] : win[WIN-1];

  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (cnt == '0) && (st == S_IDLE));

  a_r2_load_word0: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> word_o == $past(blk_i[WORD_W*WIN-1 -: WORD_W]));

  a_r3_step_count: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && st == S_RUN) |=> cnt == $past(cnt) + 1'b1);

  a_r5_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && !load_i) |=> $stable(word_o) && st == S_DONE);

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LAST));

  a_r7_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !load_i) |=> word_o == '0);

  a_r8_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(word_o));
endmodule

// File: tb/sim_msg_sched_stream.sv
`timescale 1ns/1ps
module sim_msg_sched_stream;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [511:0] blk = '0;
  logic         load = 1'b0;
  logic         step = 1'b0;
  logic [31:0]  word;
  logic [31:0]  ref_w [80];
  logic [63:0]  seed = 64'h9E37_79B9_7F4A_7C15;
  int nvec = 0;
  int nbad = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  msg_sched_stream u0 (.clk(clk), .rst_n(rst_n), .blk_i(blk), .load_i(load),
                       .step_i(step), .word_o(word));

  task automatic build(input logic [511:0] b);
    for (int i = 0; i < 16; i++) ref_w[i] = b[511-32*i -: 32];
    for (int i = 16; i < 80; i++) begin
      logic [31:0] x;
      x = ref_w[i-3] ^ ref_w[i-8] ^ ref_w[i-14] ^ ref_w[i-16];
      ref_w[i] = {x[30:0], x[31]};
    end
  endtask

  task automatic chk(input logic [31:0] exp, input string rq);
    nvec++;
    if (word !== exp) begin
      nbad++;
      $display("FAIL %s: word_o=%08h expected %08h", rq, word, exp);
    end
  endtask

  task automatic tick(input logic l, input logic s);
    load = l; step = s;
    @(negedge clk);
    load = 1'b0; step = 1'b0;
  endtask

  function automatic logic [511:0] rnd_block();
    logic [511:0] b;
    for (int i = 0; i < 16; i++) begin
      seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17;
      b[32*i +: 32] = seed[47:16];
    end
    return b;
  endfunction

  task automatic full_run(input logic [511:0] b);
    blk = b; build(b);
    tick(1'b1, 1'b0); chk(ref_w[0], "R2");
    blk = ~b;
    for (int t = 1; t < 80; t++) begin
      tick(1'b0, 1'b1);
      chk(ref_w[t], (t < 16) ? "R3" : "R4");
    end
    for (int k = 0; k < 3; k++) begin
      tick(1'b0, 1'b1); chk(ref_w[79], "R5");
    end
    tick(1'b0, 1'b0); chk(ref_w[79], "R8");
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk(32'h0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk(32'h0, "R1");
    blk = {16{32'hDEAD_BEEF}};
    tick(1'b0, 1'b1); chk(32'h0, "R7");
    tick(1'b0, 1'b1); chk(32'h0, "R7");

    full_run('0);
    full_run({512{1'b1}});
    full_run({16{32'hA5A5_5A5A}});
    begin
      logic [511:0] inc;
      for (int i = 0; i < 16; i++) inc[511-32*i -: 32] = 32'(i + 1);
      full_run(inc);
    end
    for (int n = 0; n < 12; n++) full_run(rnd_block());

    begin
      logic [511:0] b1, b2;
      b1 = rnd_block(); b2 = rnd_block();
      blk = b1; build(b1);
      tick(1'b1, 1'b0);
      for (int t = 1; t <= 40; t++) tick(1'b0, 1'b1);
      chk(ref_w[40], "R4");
      tick(1'b0, 1'b0); chk(ref_w[40], "R8");
      blk = b2; build(b2);
      tick(1'b1, 1'b1); chk(ref_w[0], "R6");
      tick(1'b1, 1'b0); chk(ref_w[0], "R6");
      for (int t = 1; t < 80; t++) begin
        tick(1'b0, 1'b1); chk(ref_w[t], "R6");
      end
      tick(1'b0, 1'b1); chk(ref_w[79], "R5");
    end

    ended = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!ended) begin
      nbad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule